// File: doc/BRIEF.md
# Fractional-Frequency PWM Generator

This block produces one or more pulse-width-modulated outputs. The frequency of each is set by a 16-bit phase increment rather than a period count. Every enabled clock adds the channel's increment to a 16-bit phase accumulator. A carry out of the accumulator marks the end of one output period, so the output frequency is the clock frequency times the increment divided by 65536. The duty cycle comes from an 8-bit threshold that is compared against the upper byte of the accumulator. A larger threshold gives a shorter high time.

Software sees each channel as one 32-bit control word on a simple synchronous register bus. Channels sit at byte addresses that are 0x400 apart. Frequency and duty writes land in a shadow copy. They reach the live generator only when software has set the self-clearing update bit and a period boundary arrives. A boundary is either an accumulator carry or the first clock after the channel is enabled, so the output never runs a period with mixed settings. Disabling a channel holds its output low and its accumulator at zero.

Top module: `pwm_frac_top`

## Requirements
- R1: After reset every control word reads 0x00000000 and every output is low.
- R2: Control word layout:
  - bit 31 is enable.
  - bit 30 is update (written as request, read as pending).
  - bits 23:8 are the shadow phase increment.
  - bits 7:0 are the shadow duty threshold.
  - bits 29:24 read 0.
  - Read data appears on rdata_o the cycle after a read request and is 0 in every cycle that follows no read.
- R3: Channel k answers at byte address k*0x400. A nonzero offset within a space, or a channel index at or above N_CH, is ignored on write and reads 0.
- R4: While running, each clock adds the active increment to the accumulator modulo 65536. A carry out is a period boundary. The increment may be any value up to 0x8002.
- R5: While running, the output is high exactly when accumulator bits 15:8 are greater than or equal to the active threshold. A threshold of 0 keeps it high.
- R6: A write changes only the shadow fields and enable. The active increment and threshold keep their values until a commit.
- R7: Writing 1 to bit 30 sets pending. Writing 0 does not clear it. At the next period boundary the shadow fields are copied to the active ones and pending clears on that same edge.
- R8: Clearing enable drives the output low from the edge of the write and holds the accumulator at 0. On the first clock after enable is set, a pending update commits and the accumulator restarts from 0.
- R9: Channels are independent. A write to one channel changes neither the state nor the output of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (12) | Byte address; channel index in the top bits |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| pwm_o | output | N_CH (3) | PWM outputs, one per channel |

## Verification
The hardest state to reach from the ports is a pending update that waits across many cycles. It must survive a second write with the update bit clear, and then commit on the exact carry edge. The bench reaches it by first committing a slow increment (period 256). It then writes a new pending configuration, rewrites it without the update bit, and reads pending before and after the boundary. A second awkward case is a commit triggered by enable rather than by a carry. The bench stages a pending update while the channel is disabled, then enables it. A cycle-level model running beside seeded random traffic checks every output bit and every read word on each cycle, including increments at the 0x8002 limit.

// File: rtl/pwm_frac_pkg.sv
package pwm_frac_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned EN_BIT     = 31;
  localparam int unsigned UPD_BIT    = 30;
  localparam int unsigned BASE_LSB   = 8;
  localparam int unsigned BASE_W     = 16;
  localparam int unsigned DIV_W      = 8;
  localparam int unsigned STRIDE_LSB = 10;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [DIV_W-1:0]  div;
  } pwm_cfg_t;

  function automatic logic [DATA_W-1:0] ctrl_word(input logic en, input logic pend,
                                                  input pwm_cfg_t cfg);
    logic [DATA_W-1:0] w;
    w = '0;
    w[EN_BIT]  = en;
    w[UPD_BIT] = pend;
    w[BASE_LSB +: BASE_W] = cfg.base;
    w[DIV_W-1:0] = cfg.div;
    return w;
  endfunction

  function automatic pwm_cfg_t ctrl_cfg(input logic [DATA_W-1:0] w);
    pwm_cfg_t c;
    c.base = w[BASE_LSB +: BASE_W];
    c.div  = w[DIV_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/pwm_frac_regif.sv
module pwm_frac_regif
  import pwm_frac_pkg::*;
#(
  parameter int unsigned N_CH   = 3,
  parameter int unsigned ADDR_W = 12
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [N_CH-1:0][DATA_W-1:0]   rd_words_i,
  output logic [N_CH-1:0]               wr_sel_o,
  output logic [DATA_W-1:0]             rdata_o
);
  localparam int unsigned CH_W = ADDR_W - STRIDE_LSB;

  logic [CH_W-1:0]   ch_idx;
  logic              hit;
  logic [DATA_W-1:0] rd_mux;

  assign ch_idx = addr_i[ADDR_W-1:STRIDE_LSB];
  assign hit    = (addr_i[STRIDE_LSB-1:0] == '0) && (32'(ch_idx) < N_CH);

  for (genvar g = 0; g < N_CH; g++) begin : g_sel
    assign wr_sel_o[g] = req_i & we_i & hit & (ch_idx == CH_W'(g));
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < N_CH; k++) begin
      if (ch_idx == CH_W'(k)) rd_mux = rd_words_i[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rdata_o <= '0;
    else if (req_i && !we_i && hit) rdata_o <= rd_mux;
    else                          rdata_o <= '0;
  end

  // R2: read data only follows a read request
  a_r2_rdata_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> rdata_o == '0);

  // R3: at most one channel selected per write
  a_r3_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel_o));
endmodule

// File: rtl/pwm_frac_cfg.sv
module pwm_frac_cfg
  import pwm_frac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              boundary_i,
  output logic              en_o,
  output pwm_cfg_t          act_o,
  output logic [DATA_W-1:0] word_o
);
  logic     en_q, pend_q, commit;
  pwm_cfg_t sh_q, act_q;
  logic     unused_bits;

  assign unused_bits = ^wdata_i[UPD_BIT-1:BASE_LSB+BASE_W];
  assign commit      = pend_q & boundary_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      sh_q   <= '0;
      act_q  <= '0;
    end else begin
      if (commit) act_q <= sh_q;
      pend_q <= (pend_q & ~commit) | (wr_i & wdata_i[UPD_BIT]);
      if (wr_i) begin
        en_q <= wdata_i[EN_BIT];
        sh_q <= ctrl_cfg(wdata_i);
      end
    end
  end

  assign en_o   = en_q;
  assign act_o  = act_q;
  assign word_o = ctrl_word(en_q, pend_q, sh_q);

  // R6: live settings move only on a commit
  a_r6_act_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(act_q));

  // R7: commit takes the shadow as it stood before the edge
  a_r7_commit_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> act_q == $past(sh_q));

  // R7: pending clears on commit unless re-requested
  a_r7_pend_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && !(wr_i && wdata_i[UPD_BIT]) |=> !pend_q);

  // R7: pending survives until a boundary
  a_r7_pend_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !boundary_i |=> pend_q);
endmodule

// File: rtl/pwm_frac_core.sv
module pwm_frac_core
  import pwm_frac_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  pwm_cfg_t act_i,
  output logic     pwm_o,
  output logic     boundary_o
);
  logic [BASE_W-1:0] acc_q;
  logic [BASE_W:0]   sum;
  logic              en_d_q, run, start, wrap;

  assign run        = en_i & en_d_q;
  assign start      = en_i & ~en_d_q;
  assign sum        = {1'b0, acc_q} + {1'b0, act_i.base};
  assign wrap       = run & sum[BASE_W];
  assign boundary_o = start | wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d_q <= 1'b0;
      acc_q  <= '0;
    end else begin
      en_d_q <= en_i;
      acc_q  <= run ? sum[BASE_W-1:0] : '0;
    end
  end

  assign pwm_o = run & (acc_q[BASE_W-1 -: DIV_W] >= act_i.div);

  // R4: a carry leaves the phase below where it was
  a_r4_wrap_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && en_d_q && boundary_o |=> acc_q < $past(acc_q));

  // R5: zero threshold keeps a running output high
  a_r5_full_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && en_d_q && act_i.div == '0 |-> pwm_o);

  // R8: disabled channel parks its phase at zero
  a_r8_acc_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> acc_q == '0);

  // R8: first enabled clock restarts the phase
  a_r8_start_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !en_d_q |=> acc_q == '0);
endmodule

// File: rtl/pwm_frac_top.sv
module pwm_frac_top
  import pwm_frac_pkg::*;
#(
  parameter int unsigned N_CH   = 3,
  parameter int unsigned ADDR_W = STRIDE_LSB + ((N_CH > 1) ? $clog2(N_CH) : 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_CH-1:0]   pwm_o
);
  logic [N_CH-1:0]             wr_sel;
  logic [N_CH-1:0][DATA_W-1:0] words;

  pwm_frac_regif #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_regif (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .rd_words_i (words),
    .wr_sel_o   (wr_sel),
    .rdata_o    (rdata_o)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic     en, boundary;
    pwm_cfg_t act;

    pwm_frac_cfg u_cfg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_sel[g]),
      .wdata_i    (wdata_i),
      .boundary_i (boundary),
      .en_o       (en),
      .act_o      (act),
      .word_o     (words[g])
    );

    pwm_frac_core u_core (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en),
      .act_i      (act),
      .pwm_o      (pwm_o[g]),
      .boundary_o (boundary)
    );
  end
endmodule

// File: tb/pwm_frac_top_tb.sv
module pwm_frac_top_tb;
  localparam int N = 3;
  localparam int AW = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [N-1:0]  pwm_o;

  int checks = 0, errors = 0;
  bit done = 0, mon_on = 0;

  pwm_frac_top #(.N_CH(N), .ADDR_W(AW)) u_dut (.*);

  always #2 clk_i = ~clk_i;

  // cycle model
  logic        m_en[N], m_pend[N], m_end[N];
  logic [15:0] m_shb[N], m_ab[N], m_acc[N];
  logic [7:0]  m_shd[N], m_ad[N];
  logic [31:0] m_rd;

  function automatic logic [31:0] word(logic en, logic pend, logic [15:0] b, logic [7:0] d);
    return {en, pend, 6'b0, b, d};
  endfunction

  function automatic logic exp_pwm(int k);
    return m_en[k] & m_end[k] & (m_acc[k][15:8] >= m_ad[k]);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N; k++) begin
        m_en[k] = 0; m_pend[k] = 0; m_end[k] = 0;
        m_shb[k] = 0; m_ab[k] = 0; m_acc[k] = 0; m_shd[k] = 0; m_ad[k] = 0;
      end
      m_rd = 0;
    end else begin
      logic hit;
      int   ch;
      ch  = int'(addr_i[11:10]);
      hit = (addr_i[9:0] == 0) && (ch < N);
      m_rd = (req_i && !we_i && hit) ? word(m_en[ch], m_pend[ch], m_shb[ch], m_shd[ch]) : 32'h0;
      for (int k = 0; k < N; k++) begin
        logic run, start, wrap, commit, wr;
        logic [16:0] sum;
        run    = m_en[k] & m_end[k];
        start  = m_en[k] & ~m_end[k];
        sum    = {1'b0, m_acc[k]} + {1'b0, m_ab[k]};
        wrap   = run & sum[16];
        commit = m_pend[k] & (start | wrap);
        wr     = req_i & we_i & hit & (ch == k);
        m_acc[k] = run ? sum[15:0] : 16'h0;
        m_end[k] = m_en[k];
        if (commit) begin m_ab[k] = m_shb[k]; m_ad[k] = m_shd[k]; end
        m_pend[k] = (m_pend[k] & ~commit) | (wr & wdata_i[30]);
        if (wr) begin
          m_en[k] = wdata_i[31]; m_shb[k] = wdata_i[23:8]; m_shd[k] = wdata_i[7:0];
        end
      end
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R5 outputs, R2 read data)
  always @(negedge clk_i) begin
    if (mon_on && rst_ni && !done) begin
      for (int k = 0; k < N; k++)
        check(pwm_o[k] == exp_pwm(k), "R5 model pwm", 32'(pwm_o[k]), 32'(exp_pwm(k)));
      check(rdata_o == m_rd, "R2 model rdata", rdata_o, m_rd);
    end
  end

  task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); req_i = 0; we_i = 0;
  endtask

  task automatic bus_read(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk_i); req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk_i); req_i = 0; d = rdata_o;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic count(int k, int n, output int hi, output int rises);
    logic prev;
    hi = 0; rises = 0;
    @(negedge clk_i); prev = pwm_o[k];
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (pwm_o[k]) hi++;
      if (pwm_o[k] && !prev) rises++;
      prev = pwm_o[k];
    end
  endtask

  task automatic read_chk(logic [AW-1:0] a, logic [31:0] exp, string tag);
    logic [31:0] d;
    bus_read(a, d);
    check(d == exp, tag, d, exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int hi, rs;
    void'($urandom(32'd20240611));
    idle(4);
    rst_ni = 1;
    mon_on = 1;
    // R1 reset state
    check(pwm_o == '0, "R1 outputs low", 32'(pwm_o), 0);
    read_chk(12'h000, 32'h0, "R1 ch0 word");
    read_chk(12'h800, 32'h0, "R1 ch2 word");

    // R5/R8 enable with update: period 16, threshold 0x80 -> 8 high
    bus_write(12'h000, word(1, 1, 16'h1000, 8'h80));
    idle(4);
    count(0, 16, hi, rs);
    check(hi == 8, "R5 duty half", hi, 8);
    count(0, 64, hi, rs);
    check(rs == 4, "R4 period 16", rs, 4);
    read_chk(12'h000, word(1, 0, 16'h1000, 8'h80), "R7 pend cleared");

    // R6 shadow write without update leaves live settings
    bus_write(12'h000, word(1, 0, 16'h2000, 8'h40));
    read_chk(12'h000, word(1, 0, 16'h2000, 8'h40), "R2 shadow readback");
    count(0, 16, hi, rs);
    check(hi == 8, "R6 active unchanged", hi, 8);
    bus_write(12'h000, word(1, 1, 16'h2000, 8'h40));
    idle(20);
    count(0, 8, hi, rs);
    check(hi == 6, "R7 committed duty", hi, 6);

    // R7 long pending, write of 0 keeps it
    bus_write(12'h000, word(1, 1, 16'h0100, 8'h80));
    idle(20);
    bus_write(12'h000, word(1, 1, 16'h0200, 8'h10));
    read_chk(12'h000, word(1, 1, 16'h0200, 8'h10), "R7 pend set");
    bus_write(12'h000, word(1, 0, 16'h0200, 8'h10));
    read_chk(12'h000, word(1, 1, 16'h0200, 8'h10), "R7 pend sticky");
    idle(300);
    read_chk(12'h000, word(1, 0, 16'h0200, 8'h10), "R7 pend done");

    // R8 disable forces low
    bus_write(12'h000, word(1, 1, 16'h2000, 8'h00));
    idle(20);
    count(0, 16, hi, rs);
    check(hi == 16, "R5 zero threshold high", hi, 16);
    bus_write(12'h000, word(0, 0, 16'h2000, 8'h00));
    check(pwm_o[0] == 0, "R8 low at disable", 32'(pwm_o[0]), 0);
    count(0, 20, hi, rs);
    check(hi == 0, "R8 stays low", hi, 0);

    // R8 pending staged while off commits on enable
    bus_write(12'h000, word(0, 1, 16'h4000, 8'hC0));
    idle(10);
    read_chk(12'h000, word(0, 1, 16'h4000, 8'hC0), "R8 pend held off");
    bus_write(12'h000, word(1, 0, 16'h4000, 8'hC0));
    read_chk(12'h000, word(1, 0, 16'h4000, 8'hC0), "R8 commit on enable");
    idle(8);
    count(0, 16, hi, rs);
    check(hi == 4, "R8 new duty", hi, 4);

    // R3 decode misses
    bus_write(12'h004, word(1, 1, 16'h0300, 8'h11));
    bus_write(12'hC00, word(1, 1, 16'h0300, 8'h11));
    read_chk(12'h000, word(1, 0, 16'h4000, 8'hC0), "R3 offset write ignored");
    read_chk(12'h004, 32'h0, "R3 offset read zero");
    read_chk(12'hC00, 32'h0, "R3 index read zero");

    // R9 independence
    bus_write(12'h400, word(1, 1, 16'h1122, 8'h33));
    read_chk(12'h400, word(1, 0, 16'h1122, 8'h33), "R9 ch1 word");
    read_chk(12'h000, word(1, 0, 16'h4000, 8'hC0), "R9 ch0 untouched");
    read_chk(12'h800, 32'h0, "R9 ch2 untouched");

    // R4 upper bound increment
    bus_write(12'h800, word(1, 1, 16'h8002, 8'h80));
    idle(6);
    count(2, 64, hi, rs);
    check(rs == 32, "R4 limit increment", rs, 32);

    // random phase, checked by the model every cycle
    for (int i = 0; i < 2500; i++) begin
      int sel;
      sel = int'($urandom_range(9, 0));
      if (sel < 4) begin
        logic [AW-1:0] a;
        a = AW'(($urandom_range(N - 1, 0)) << 10);
        bus_write(a, word($urandom_range(9, 0) < 8, $urandom_range(1, 0) == 1,
                          16'($urandom_range(32'h8002, 1)), 8'($urandom)));
      end else if (sel < 8) begin
        logic [31:0] d;
        logic [AW-1:0] a;
        a = ($urandom_range(7, 0) == 0) ? AW'($urandom) : AW'(($urandom_range(3, 0)) << 10);
        bus_read(a, d);
      end else begin
        idle(int'($urandom_range(12, 1)));
      end
    end

    idle(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule